// File: doc/BRIEF.md
# Configuration Lock Key Sequencer

This block holds the per-pin lock word of a general-purpose I/O port. It watches the port's register bus for accesses to one offset, the lock register. It accepts a lock only after a fixed key sequence of three writes and one read. Until that sequence completes, software may freely rewrite the 16-bit mask. Once the sequence completes, a sticky key bit is set and the mask is frozen until reset.

The frozen mask goes to the configuration register bank. There, a 1 in bit i blocks changes to pin i's settings, and a 0 leaves the pin free. This block does not protect the configuration fields itself; the register bank does that. The block also returns the read data for the lock offset.

The key sequence uses the key bit, which is bit 16 of the lock register, and the mask M in bits [15:0]:
1. a full-word write with key bit 1 and mask M;
2. a full-word write with key bit 0 and the same M;
3. a full-word write with key bit 1 and the same M;
4. a read of the lock offset.

Top module: `cfg_lock_seq`

## Requirements
- R1: After reset, the mask is 0, the key bit is 0, `lock_mask_o` is 0 and `rdata_o` is 0.
- R2: A lock access is a cycle with `acc_valid_i`=1 and `acc_addr_i`=LOCK_OFFSET (0x1C by default). The key sequence of R2 is, in this order: a full-word write with bit 16=1 and mask M, then a full-word write with bit 16=0 and M, then a full-word write with bit 16=1 and M, then a read. From the clock edge that takes the read onward, `rdata_o[16]`=1 and `lock_mask_o`=M.
- R3: If any of the three writes carries a value in bits [15:0] different from the first write's, the sequence is aborted, and the following read does not lock.
- R4: A lock write whose byte enables are not all ones (`acc_be_i`≠4'hF) aborts a sequence in progress. It never counts as a sequence step.
- R5: Any other deviation aborts the sequence and returns it to idle: a read too early, or a wrong key bit value. A new sequence starts only with a fresh first step (full word, bit 16=1). A later read therefore does not lock unless all three writes have been made again.
- R6: Accesses to offsets other than LOCK_OFFSET neither advance nor abort a sequence.
- R7: While unlocked, any lock write updates mask bits [15:0] for the bytes whose enable bit is 1. The key bit is never set by a write. `rdata_o` is {15'b0, key, mask}, so bits [31:17] read 0.
- R8: Once locked, the key bit stays 1 and writes leave the mask unchanged until reset.
- R9: `lock_mask_o` is 0 while unlocked and equals the frozen mask while locked.
- R10: After the third write of a valid sequence, and before the read, `lock_mask_o` is still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Bus access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Register offset of the access |
| acc_be_i | input | DATA_W/8 | Byte enables of a write |
| acc_wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Lock register read value |
| lock_mask_o | output | MASK_W | Active per-pin lock mask to the register bank |

## Verification
Every access is taken on one rising edge. The sequencer state, the mask and both outputs reflect that access directly after the edge, with no further pipeline stage. The bench therefore drives an access on a falling edge and samples the outputs one edge later, just after the next rising edge. It checks `lock_mask_o` at two points: after the third write, where it must still be zero, and after the read, where the lock must take effect. This separates "locks on the read" from "locks on the third write".

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_ARM1   = 3'd1,
    SEQ_ARM0   = 3'd2,
    SEQ_ARM2   = 3'd3,
    SEQ_LOCKED = 3'd4
  } seq_state_e;
endpackage

// File: rtl/cfg_lock_decode.sv
module cfg_lock_decode #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int MASK_W      = 16,
  parameter logic [ADDR_W-1:0] LOCK_OFFSET = 8'h1C,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              wr_any_o,
  output logic              wr_word_o,
  output logic              rd_o,
  output logic              key_bit_o,
  output logic [MASK_W-1:0] wmask_o
);
  always_comb begin
    hit_o     = valid_i && (addr_i == LOCK_OFFSET);
    wr_any_o  = hit_o && write_i;
    wr_word_o = wr_any_o && (&be_i);
    rd_o      = hit_o && !write_i;
    key_bit_o = wdata_i[MASK_W];
    wmask_o   = wdata_i[MASK_W-1:0];
  end
endmodule

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
  import cfg_lock_pkg::*;
#(
  parameter int MASK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              wr_any_i,
  input  logic              wr_word_i,
  input  logic              rd_i,
  input  logic              key_bit_i,
  input  logic [MASK_W-1:0] wmask_i,
  output logic              locked_o
);
  seq_state_e        state_q, state_d;
  logic [MASK_W-1:0] seq_mask_q;
  logic              same_mask;

  assign same_mask = (wmask_i == seq_mask_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (wr_word_i && key_bit_i) state_d = SEQ_ARM1;
      SEQ_ARM1: if (hit_i)
        state_d = (wr_word_i && !key_bit_i && same_mask) ? SEQ_ARM0 : SEQ_IDLE;
      SEQ_ARM0: if (hit_i)
        state_d = (wr_word_i && key_bit_i && same_mask) ? SEQ_ARM2 : SEQ_IDLE;
      SEQ_ARM2: if (hit_i) state_d = rd_i ? SEQ_LOCKED : SEQ_IDLE;
      SEQ_LOCKED: state_d = SEQ_LOCKED;
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      seq_mask_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_IDLE && wr_word_i && key_bit_i) seq_mask_q <= wmask_i;
    end
  end

  assign locked_o = (state_q == SEQ_LOCKED);

  // R2
  read_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_ARM2 && rd_i) |=> locked_o);
  // R3
  mask_mismatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_ARM1 && wr_word_i && wmask_i != seq_mask_q) |=> state_q == SEQ_IDLE);
  // R4
  partial_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == SEQ_ARM1 || state_q == SEQ_ARM0 || state_q == SEQ_ARM2)
     && wr_any_i && !wr_word_i) |=> state_q == SEQ_IDLE);
  // R6
  other_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> $stable(state_q));
  // R8
  key_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
endmodule

// File: rtl/cfg_lock_mask_reg.sv
module cfg_lock_mask_reg #(
  parameter int MASK_W = 16,
  parameter int BE_W   = 4,
  localparam int MASK_BYTES = MASK_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_any_i,
  input  logic              locked_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [MASK_W-1:0] wmask_i,
  output logic [MASK_W-1:0] mask_o
);
  logic wr_en;
  assign wr_en = wr_any_i && !locked_i;

  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_o[b*8 +: 8] <= '0;
      else if (wr_en && be_i[b]) mask_o[b*8 +: 8] <= wmask_i[b*8 +: 8];
    end
  end

  // R7
  byte_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any_i && !locked_i && be_i[0]) |=> mask_o[7:0] == $past(wmask_i[7:0]));
  // R8
  mask_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(mask_o));
endmodule

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int MASK_W = 16,
  parameter logic [ADDR_W-1:0] LOCK_OFFSET = 8'h1C,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [BE_W-1:0]   acc_be_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MASK_W-1:0] lock_mask_o
);
  logic              hit, wr_any, wr_word, rd, key_bit, locked;
  logic [MASK_W-1:0] wmask, mask_q;

  cfg_lock_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W), .LOCK_OFFSET(LOCK_OFFSET)
  ) u_decode (
    .valid_i(acc_valid_i), .write_i(acc_write_i), .addr_i(acc_addr_i),
    .be_i(acc_be_i), .wdata_i(acc_wdata_i),
    .hit_o(hit), .wr_any_o(wr_any), .wr_word_o(wr_word), .rd_o(rd),
    .key_bit_o(key_bit), .wmask_o(wmask)
  );

  cfg_lock_fsm #(.MASK_W(MASK_W)) u_fsm (
    .clk_i, .rst_ni, .hit_i(hit), .wr_any_i(wr_any), .wr_word_i(wr_word),
    .rd_i(rd), .key_bit_i(key_bit), .wmask_i(wmask), .locked_o(locked)
  );

  cfg_lock_mask_reg #(.MASK_W(MASK_W), .BE_W(BE_W)) u_mask (
    .clk_i, .rst_ni, .wr_any_i(wr_any), .locked_i(locked),
    .be_i(acc_be_i), .wmask_i(wmask), .mask_o(mask_q)
  );

  always_comb begin
    rdata_o = '0;
    rdata_o[MASK_W] = locked;
    rdata_o[MASK_W-1:0] = mask_q;
  end

  assign lock_mask_o = locked ? mask_q : '0;

  // R9
  lock_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdata_o[MASK_W]) |-> $past(rd));
endmodule

// File: tb/cfg_lock_seq_test.sv
`timescale 1ns/1ps
module cfg_lock_seq_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid = 0, write = 0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] lmask;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cfg_lock_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(write),
    .acc_addr_i(addr), .acc_be_i(be), .acc_wdata_i(wdata),
    .rdata_o(rdata), .lock_mask_o(lmask)
  );

  // op: 0 idle, 1 write, 2 read | addr | be | wdata | expected rdata
  localparam int VW = 78;
  localparam logic [VW-1:0] VEC [8] = '{
    {2'd1, 8'h1C, 4'hF, 32'h0001_00A5, 32'h0000_00A5},
    {2'd1, 8'h10, 4'hF, 32'h0000_FFFF, 32'h0000_00A5},
    {2'd1, 8'h1C, 4'hF, 32'h0000_00A5, 32'h0000_00A5},
    {2'd2, 8'h14, 4'h0, 32'h0000_0000, 32'h0000_00A5},
    {2'd1, 8'h1C, 4'hF, 32'h0001_00A5, 32'h0000_00A5},
    {2'd2, 8'h1C, 4'h0, 32'h0000_0000, 32'h0001_00A5},
    {2'd1, 8'h1C, 4'hF, 32'h0000_1234, 32'h0001_00A5},
    {2'd1, 8'h1C, 4'h1, 32'h0001_FFFF, 32'h0001_00A5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] op, input logic [7:0] a, input logic [3:0] b,
                     input logic [31:0] d);
    @(negedge clk);
    valid = (op != 0); write = (op == 1); addr = a; be = b; wdata = d;
    @(posedge clk);
    #1 valid = 0; write = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    acc(2'd1, 8'h1C, 4'hF, d);
  endtask

  task automatic rd_lock();
    acc(2'd2, 8'h1C, 4'h0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 lock_mask", {16'h0, lmask}, 32'h0);
    rst_n = 1;

    // table: R7 R6 R10 R2 R8 R9
    for (int i = 0; i < 8; i++) begin
      logic [31:0] er;
      acc(VEC[i][77:76], VEC[i][75:68], VEC[i][67:64], VEC[i][63:32]);
      er = VEC[i][31:0];
      chk($sformatf("R2/R6/R7/R8 vec%0d rdata", i), rdata, er);
      chk($sformatf("R9/R10 vec%0d lock_mask", i), {16'h0, lmask},
          er[16] ? {16'h0, er[15:0]} : 32'h0);
    end

    // R8 reset clears the lock
    do_reset();
    chk("R1 after lock reset", rdata, 32'h0);

    // R3 mask changes mid-sequence
    wr(32'h0001_000F); wr(32'h0000_00F0); wr(32'h0001_00F0); rd_lock();
    chk("R3 no lock", rdata, 32'h0000_00F0);
    chk("R3 lock_mask", {16'h0, lmask}, 32'h0);

    // R4 partial write mid-sequence
    do_reset();
    wr(32'h0001_00A5);
    acc(2'd1, 8'h1C, 4'h3, 32'h0000_00A5);
    wr(32'h0001_00A5); rd_lock();
    chk("R4 no lock", rdata, 32'h0000_00A5);

    // R5 early read aborts, no fresh start -> no lock
    do_reset();
    wr(32'h0001_003C); rd_lock(); wr(32'h0000_003C); wr(32'h0001_003C); rd_lock();
    chk("R5 no lock", rdata, 32'h0000_003C);
    wr(32'h0001_003C); wr(32'h0000_003C); wr(32'h0001_003C);
    chk("R10 before read", {16'h0, lmask}, 32'h0);
    rd_lock();
    chk("R5 fresh sequence locks", rdata, 32'h0001_003C);
    chk("R9 frozen mask", {16'h0, lmask}, 32'h0000_003C);

    // R7 byte enables and reserved bits
    do_reset();
    acc(2'd1, 8'h1C, 4'h1, 32'hFFFF_FF5A);
    chk("R7 byte write", rdata, 32'h0000_005A);
    wr(32'hFFFE_1111);
    chk("R7 reserved zero", rdata, 32'h0000_1111);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule